// File: doc/BRIEF.md
# Windowed Pattern-Match Trigger Unit

This block watches a stream of comparator results, one result per sample, and raises a trigger when the most recent stretch of the waveform has a programmed shape. Each sample has two comparator bits: one is set when the sample is above an upper threshold and the other is set when it is below a lower threshold. The block turns this pair into a three-level class and stores it in a circular history of 128 positions. The write position moves forward by one for each accepted sample.

At every accepted sample the block compares the newest eight classes with a bank of 72 programmable patterns, all in parallel. The eight-sample window slides one sample at a time and wraps around the end of the history. Each pattern position asks for high, low or middle, or accepts any class. When any enabled pattern matches, the unit freezes the history, emits a single trigger pulse, and reports two values: the lowest matching pattern number and the history position of the sample that completed the window. Software loads patterns while the unit is not armed. An arm pulse then clears the status and restarts acquisition from where the history stopped.

Top module: `pattern_trigger`

## Requirements
- R1: After reset the outputs are as follows. `armed`, `triggered` and `trig_pulse` are 0. `trig_idx` and `trig_pos` are 0. Every history entry reads 0. The write position is 0. Every pattern is disabled.
- R2: Each accepted sample is stored at the write position as a 2-bit class, readable on `hist_cls` for the address on `hist_addr`. The class codes are: high-only = 2'b10, low-only = 2'b01, neither = 2'b11. The write position then advances by one and wraps from 127 to 0. A sample is accepted when `smp_valid` is 1, the unit is armed, `arm` is 0 and no match is pending.
- R3: Pattern bits [2p+1:2p] apply to the sample that is p samples older than the newest one (p = 0 is the newest). The position codes are 00 = any, 01 = low, 10 = high, 11 = middle. A sample with both comparator bits set is stored as 00 and matches only code 00.
- R4: A window is compared only once at least 8 samples have been accepted since the last arm. Windows may span the wrap from position 127 to position 0.
- R5: A sample that completes a matching window is captured on clock edge k. `trig_pulse` is then 1 for exactly the one cycle that follows edge k+1.
- R6: On a trigger the unit reports `trig_idx` and `trig_pos`. `trig_idx` is the lowest-numbered enabled pattern that matches. `trig_pos` is the history position of the newest sample in the window. Both values and `triggered` are held until the next arm.
- R7: While triggered, no sample is written. The write position and all history entries stay unchanged.
- R8: Pattern writes (`pat_we` with `pat_idx`, `pat_word`, `pat_en`) take effect only while `armed` is 0, and only for an index below 72. A disabled pattern never matches.
- R9: An `arm` pulse does the following, in any state:
  - sets `armed`;
  - clears `triggered`, `trig_idx` and `trig_pos`;
  - drops any pending match and any sample offered in that cycle;
  - restarts the 8-sample count.

  Acquisition resumes at the frozen write position.
- R10: The pattern word 16'h9999 matches eight samples that alternate high and low and end with a low sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | A new sample is present |
| smp_hi | input | 1 | Sample above the upper threshold |
| smp_lo | input | 1 | Sample below the lower threshold |
| arm | input | 1 | Arm / rearm pulse |
| pat_we | input | 1 | Pattern write strobe |
| pat_idx | input | 7 | Pattern number to write |
| pat_word | input | 16 | Eight 2-bit position codes |
| pat_en | input | 1 | Enable for the written pattern |
| hist_addr | input | 7 | History read address |
| hist_cls | output | 2 | Class stored at `hist_addr` |
| armed | output | 1 | Acquisition running |
| triggered | output | 1 | Trigger status, held until arm |
| trig_pulse | output | 1 | One-cycle trigger event |
| trig_idx | output | 7 | Lowest matching pattern |
| trig_pos | output | 7 | Position of the window's newest sample |

## Verification
The hardest case to reach is a match whose window straddles the wrap of the history at the same moment the freeze must stop the very next sample. The write position can only be moved by feeding samples. The stimulus therefore first feeds middle-level samples, which no enabled pattern accepts, until a reference model of the write position reads 125. It then feeds an alternating high/low burst, so the completing sample lands at position 4. Random runs follow. They use patterns made mostly of "any" positions and rare invalid comparator pairs, which produces many triggers at uneven phases around the ring.

// File: rtl/pt_pkg.sv
package pt_pkg;

  typedef logic [1:0] cls_t;

  localparam cls_t CLS_ANY = 2'b00;
  localparam cls_t CLS_LO  = 2'b01;
  localparam cls_t CLS_HI  = 2'b10;
  localparam cls_t CLS_MID = 2'b11;

  typedef enum logic [1:0] {ST_IDLE, ST_ARMED, ST_TRIG} pt_state_t;

  // Comparator pair to class; both bits set is invalid and maps to CLS_ANY
  function automatic cls_t classify(input logic above, input logic below);
    cls_t c;
    unique case ({above, below})
      2'b10:   c = CLS_HI;
      2'b01:   c = CLS_LO;
      2'b00:   c = CLS_MID;
      default: c = CLS_ANY;
    endcase
    return c;
  endfunction

  // One pattern position against one stored class
  function automatic logic sym_ok(input cls_t want, input cls_t got);
    return (want == CLS_ANY) || (want == got);
  endfunction

endpackage

// File: rtl/pt_ring.sv
module pt_ring
  import pt_pkg::*;
#(
  parameter int DEPTH = 128,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  cls_t          din,
  output logic [AW-1:0] wptr,
  output logic [AW-1:0] newest,
  input  logic [AW-1:0] rd_addr,
  output cls_t          rd_data
);

  cls_t mem [DEPTH];

  function automatic logic [AW-1:0] step_fwd(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  function automatic logic [AW-1:0] step_back(input logic [AW-1:0] p);
    return (p == '0) ? AW'(DEPTH - 1) : p - AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= CLS_ANY;
    end else if (we) begin
      mem[wptr] <= din;
      wptr      <= step_fwd(wptr);
    end
  end

  assign newest  = step_back(wptr);
  assign rd_data = mem[rd_addr];

  // R2: the write position wraps from the last entry to zero
  p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (we && wptr == AW'(DEPTH - 1)) |=> (wptr == '0));

  // R7: without a write the position does not move
  p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(wptr));

endmodule

// File: rtl/pt_window.sv
module pt_window
  import pt_pkg::*;
#(
  parameter int WIN = 8,
  parameter int CW  = $clog2(WIN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             we,
  input  cls_t             din,
  output logic [2*WIN-1:0] win,
  output logic             full
);

  logic [CW-1:0] fill;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win  <= '0;
      fill <= '0;
    end else begin
      if (we) win <= {win[2*WIN-3:0], din};
      if (clr) fill <= '0;
      else if (we && !full) fill <= fill + CW'(1);
    end
  end

  assign full = (fill == CW'(WIN));

  // R4: the window becomes valid only through an accepted sample, never on arm
  p_fill_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(full) |-> ($past(we) && !$past(clr)));

endmodule

// File: rtl/pt_matcher.sv
module pt_matcher
  import pt_pkg::*;
#(
  parameter int WIN  = 8,
  parameter int NPAT = 72,
  parameter int PW   = $clog2(NPAT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [PW-1:0]    wr_idx,
  input  logic [2*WIN-1:0] wr_word,
  input  logic             wr_en,
  input  logic [2*WIN-1:0] win,
  output logic             any_hit,
  output logic [PW-1:0]    first_idx
);

  logic [NPAT-1:0] hit_vec;

  for (genvar g = 0; g < NPAT; g++) begin : g_pat
    logic [2*WIN-1:0] word_q;
    logic             en_q;
    logic [WIN-1:0]   pos_ok;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        word_q <= '0;
        en_q   <= 1'b0;
      end else if (wr && wr_idx == PW'(g)) begin
        word_q <= wr_word;
        en_q   <= wr_en;
      end
    end

    for (genvar p = 0; p < WIN; p++) begin : g_pos
      assign pos_ok[p] = sym_ok(word_q[2*p +: 2], win[2*p +: 2]);
    end

    assign hit_vec[g] = en_q & (&pos_ok);
  end

  always_comb begin
    first_idx = '0;
    for (int i = NPAT - 1; i >= 0; i--) begin
      if (hit_vec[i]) first_idx = PW'(i);
    end
  end

  assign any_hit = |hit_vec;

  // R6: the reported pattern does match
  p_first_hits_r6: assert property (@(posedge clk) disable iff (!rst_n)
    any_hit |-> hit_vec[first_idx]);

  // R6: no lower-numbered pattern matches
  p_lowest_r6: assert property (@(posedge clk) disable iff (!rst_n)
    any_hit |-> ((hit_vec & ((NPAT'(1) << first_idx) - NPAT'(1))) == '0));

endmodule

// File: rtl/pattern_trigger.sv
module pattern_trigger
  import pt_pkg::*;
#(
  parameter int DEPTH = 128,
  parameter int WIN   = 8,
  parameter int NPAT  = 72,
  localparam int AW   = $clog2(DEPTH),
  localparam int PW   = $clog2(NPAT),
  localparam int WW   = 2 * WIN
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_valid,
  input  logic          smp_hi,
  input  logic          smp_lo,
  input  logic          arm,
  input  logic          pat_we,
  input  logic [PW-1:0] pat_idx,
  input  logic [WW-1:0] pat_word,
  input  logic          pat_en,
  input  logic [AW-1:0] hist_addr,
  output logic [1:0]    hist_cls,
  output logic          armed,
  output logic          triggered,
  output logic          trig_pulse,
  output logic [PW-1:0] trig_idx,
  output logic [AW-1:0] trig_pos
);

  pt_state_t     st;
  logic          hit;
  logic          ring_we;
  logic          pat_wr;
  logic          win_full;
  logic          any_hit;
  logic [PW-1:0] first_idx;
  logic [WW-1:0] win;
  logic [AW-1:0] wptr;
  logic [AW-1:0] newest;
  cls_t          smp_cls;
  cls_t          rd_cls;

  assign smp_cls = classify(smp_hi, smp_lo);
  assign hit     = (st == ST_ARMED) && win_full && any_hit && !arm;
  assign ring_we = (st == ST_ARMED) && smp_valid && !hit && !arm;
  assign pat_wr  = pat_we && (st != ST_ARMED) && (pat_idx < PW'(NPAT));

  pt_ring #(.DEPTH(DEPTH), .AW(AW)) i_ring (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (ring_we),
    .din     (smp_cls),
    .wptr    (wptr),
    .newest  (newest),
    .rd_addr (hist_addr),
    .rd_data (rd_cls)
  );

  pt_window #(.WIN(WIN)) i_window (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (arm),
    .we    (ring_we),
    .din   (smp_cls),
    .win   (win),
    .full  (win_full)
  );

  pt_matcher #(.WIN(WIN), .NPAT(NPAT), .PW(PW)) i_matcher (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr        (pat_wr),
    .wr_idx    (pat_idx),
    .wr_word   (pat_word),
    .wr_en     (pat_en),
    .win       (win),
    .any_hit   (any_hit),
    .first_idx (first_idx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      trig_pulse <= 1'b0;
      trig_idx   <= '0;
      trig_pos   <= '0;
    end else begin
      trig_pulse <= 1'b0;
      if (arm) begin
        st       <= ST_ARMED;
        trig_idx <= '0;
        trig_pos <= '0;
      end else if (hit) begin
        st         <= ST_TRIG;
        trig_pulse <= 1'b1;
        trig_idx   <= first_idx;
        trig_pos   <= newest;
      end
    end
  end

  assign armed     = (st == ST_ARMED);
  assign triggered = (st == ST_TRIG);
  assign hist_cls  = rd_cls;

  // R5: the trigger event lasts one cycle
  p_pulse_once_r5: assert property (@(posedge clk) disable iff (!rst_n)
    trig_pulse |=> !trig_pulse);

  // R5: a pulse follows a full window seen in the previous cycle
  p_pulse_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
    trig_pulse |-> (triggered && $past(win_full)));

  // R6: status is held until the next arm
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (triggered && !arm) |=> (triggered && $stable(trig_idx) && $stable(trig_pos)));

  // R7: the history write position is frozen while triggered
  p_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (triggered && !arm) |=> $stable(wptr));

  // R9: arm always lands in the armed state with status cleared
  p_arm_r9: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> (armed && !triggered && !trig_pulse));

endmodule

// File: tb/test_pattern_trigger.sv
`timescale 1ns/1ps
module test_pattern_trigger;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        smp_valid = 1'b0, smp_hi = 1'b0, smp_lo = 1'b0, arm = 1'b0;
  logic        pat_we = 1'b0, pat_en = 1'b0;
  logic [6:0]  pat_idx = '0;
  logic [15:0] pat_word = '0;
  logic [6:0]  hist_addr = '0;
  logic [1:0]  hist_cls;
  logic        armed, triggered, trig_pulse;
  logic [6:0]  trig_idx, trig_pos;

  always #2 clk = ~clk;

  pattern_trigger i_pattern_trigger (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_hi(smp_hi), .smp_lo(smp_lo),
    .arm(arm), .pat_we(pat_we), .pat_idx(pat_idx), .pat_word(pat_word), .pat_en(pat_en),
    .hist_addr(hist_addr), .hist_cls(hist_cls), .armed(armed), .triggered(triggered),
    .trig_pulse(trig_pulse), .trig_idx(trig_idx), .trig_pos(trig_pos)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // reference model
  int          m_ring [128];
  int          m_wp = 0, m_cnt = 0, m_state = 0;   // 0 idle, 1 armed, 2 triggered
  bit          m_pend = 0;
  int          m_pidx = 0, m_ppos = 0, m_tidx = 0, m_tpos = 0;
  logic [15:0] m_pat [72];
  bit          m_en [72];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int cls_of(input bit h, input bit l);
    if (h && l) return 0;
    if (h) return 2;
    if (l) return 1;
    return 3;
  endfunction

  function automatic bit pat_fits(input logic [15:0] w, input int newest);
    for (int p = 0; p < 8; p++) begin
      int want = int'(w[2*p +: 2]);
      int got  = m_ring[(newest - p + 128) % 128];
      if (want != 0 && want != got) return 0;
    end
    return 1;
  endfunction

  task automatic tick(input bit v, input bit h, input bit l);
    smp_valid = v; smp_hi = h; smp_lo = l;
    @(posedge clk); #1;
    if (m_pend) begin
      m_pend = 0; m_state = 2; m_tidx = m_pidx; m_tpos = m_ppos;
      chk(trig_pulse == 1'b1, "R5 pulse", int'(trig_pulse), 1);
      chk(trig_idx == 7'(m_tidx), "R6 index", int'(trig_idx), m_tidx);
      chk(trig_pos == 7'(m_tpos), "R6 position", int'(trig_pos), m_tpos);
    end else begin
      chk(trig_pulse == 1'b0, "R5 no pulse", int'(trig_pulse), 0);
      if (m_state == 1 && v) begin
        int nw = m_wp;
        m_ring[m_wp] = cls_of(h, l);
        m_wp = (m_wp + 1) % 128;
        if (m_cnt < 8) m_cnt++;
        if (m_cnt == 8) begin
          for (int i = 71; i >= 0; i--) begin
            if (m_en[i] && pat_fits(m_pat[i], nw)) begin
              m_pend = 1; m_pidx = i; m_ppos = nw;
            end
          end
        end
      end
    end
    chk(triggered == (m_state == 2), "R7 status", int'(triggered), int'(m_state == 2));
    smp_valid = 0;
    @(negedge clk);
  endtask

  task automatic do_arm;
    arm = 1;
    @(posedge clk); #1;
    arm = 0;
    m_state = 1; m_cnt = 0; m_pend = 0; m_tidx = 0; m_tpos = 0;
    chk(armed == 1'b1, "R9 armed", int'(armed), 1);
    chk(triggered == 1'b0 && trig_idx == 0 && trig_pos == 0, "R9 cleared",
        int'(triggered), 0);
    @(negedge clk);
  endtask

  task automatic wr_pat(input int idx, input logic [15:0] w, input bit en);
    pat_we = 1; pat_idx = 7'(idx); pat_word = w; pat_en = en;
    @(posedge clk); #1;
    pat_we = 0;
    if (m_state != 1 && idx < 72) begin
      m_pat[idx] = w; m_en[idx] = en;
    end
    @(negedge clk);
  endtask

  task automatic ring_chk(input string req);
    for (int a = 0; a < 128; a++) begin
      hist_addr = 7'(a);
      #0.1;
      chk(int'(hist_cls) == m_ring[a], req, int'(hist_cls), m_ring[a]);
    end
  endtask

  task automatic alt8;
    for (int k = 0; k < 8; k++) tick(1, (k % 2) == 0, (k % 2) == 1);
  endtask

  function automatic logic [15:0] rand_pat();
    logic [15:0] w;
    for (int p = 0; p < 8; p++) begin
      int r = int'($urandom % 8);
      w[2*p +: 2] = (r < 4) ? 2'b00 : (r == 4) ? 2'b01 : (r == 5) ? 2'b10 : 2'b11;
    end
    return w;
  endfunction

  task automatic rand_tick;
    int r = int'($urandom % 16);
    bit v = ($urandom % 8) != 0;
    tick(v, r == 0 || (r >= 1 && r <= 5), r == 0 || (r >= 6 && r <= 10));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 128; i++) m_ring[i] = 0;
    for (int i = 0; i < 72; i++) begin m_pat[i] = '0; m_en[i] = 0; end
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1;
    @(negedge clk);

    // R1 reset state
    chk(armed == 0 && triggered == 0 && trig_pulse == 0, "R1 flags", int'(armed), 0);
    chk(trig_idx == 0 && trig_pos == 0, "R1 status", int'(trig_pos), 0);
    ring_chk("R1 history");

    // R4: all-any pattern fires exactly on the 8th sample since arm
    wr_pat(5, 16'h0000, 1);
    do_arm;
    for (int k = 0; k < 7; k++) tick(1, 0, 0);
    chk(triggered == 0, "R4 early", int'(triggered), 0);
    tick(1, 0, 0);
    tick(0, 0, 0);
    chk(trig_idx == 5 && trig_pos == 7, "R6 first window", int'(trig_pos), 7);
    ring_chk("R2 stored classes");

    // R8: write while armed ignored; R10 alternating pattern
    wr_pat(5, 16'h0000, 0);
    wr_pat(3, 16'h9999, 1);
    do_arm;
    wr_pat(0, 16'h0000, 1);
    for (int k = 0; k < 12; k++) tick(1, 0, 0);
    chk(triggered == 0, "R8 armed write ignored", int'(triggered), 0);
    wr_pat(72, 16'h0000, 1);
    alt8;
    tick(0, 0, 0);
    chk(triggered == 1 && trig_idx == 3, "R10 alternating", int'(trig_idx), 3);

    // R7 freeze
    for (int k = 0; k < 10; k++) tick(1, k[0], !k[0]);
    chk(trig_pos == 7'(m_tpos), "R7 position held", int'(trig_pos), m_tpos);
    ring_chk("R7 history frozen");

    // R6 lowest index wins
    wr_pat(1, 16'h9999, 1);
    do_arm;
    alt8;
    tick(0, 0, 0);
    chk(trig_idx == 1, "R6 lowest", int'(trig_idx), 1);

    // R3 invalid sample matches only "any"
    wr_pat(1, 16'h9999, 0);
    wr_pat(3, 16'h9999, 0);
    wr_pat(7, 16'hFFFF, 1);
    do_arm;
    for (int k = 0; k < 7; k++) tick(1, 0, 0);
    tick(1, 1, 1);
    for (int k = 0; k < 7; k++) tick(1, 0, 0);
    chk(triggered == 0, "R3 invalid blocks", int'(triggered), 0);
    tick(1, 0, 0);
    tick(0, 0, 0);
    chk(triggered == 1 && trig_idx == 7, "R3 middle match", int'(trig_idx), 7);

    // R4 window across the wrap
    wr_pat(7, 16'hFFFF, 0);
    wr_pat(3, 16'h9999, 1);
    do_arm;
    while (m_wp != 125) tick(1, 0, 0);
    alt8;
    tick(0, 0, 0);
    chk(triggered == 1 && trig_pos == 4, "R4 wrap window", int'(trig_pos), 4);
    ring_chk("R2 wrap history");

    // random rounds
    for (int rnd = 0; rnd < 40; rnd++) begin
      int guard = 0;
      for (int k = 0; k < 8; k++) wr_pat(int'($urandom % 72), rand_pat(), ($urandom % 3) == 0);
      wr_pat(71, 16'h003F, 1);
      do_arm;
      while (m_state != 2 && guard < 2000) begin rand_tick; guard++; end
      for (int k = 0; k < 3; k++) rand_tick;
      if (rnd % 8 == 0) ring_chk("R7 random history");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule